// File: doc/BRIEF.md
# Serial Control Register Port

This block is a three-wire serial control slave. A host shifts 16-bit command words in on a data line, clocked by its own bit clock, and marks the end of each word with a rising edge on a latch line. The two lowest bits of a word select one of four registers: the general control word, the clock/bitstream control word, the left volume or the right volume. The upper bits carry that register's contents.

The bit clock may run without pause or only as a burst of sixteen pulses per word. It has no timing relationship to the audio sample clock. Each committed word is held in a capture register. A toggle then crosses into the sample-clock domain, and the addressed register is updated there in a single cycle. Every decoded field is presented as a parallel output in the sample-clock domain. A control-0 word that carries the forbidden output-format code is discarded. An active-low asynchronous reset restores every register to its default value.

Top module: `serial_ctrl_regs`

## Requirements
- R1: The data line is sampled on each rising bit-clock edge, MSB first. With a free-running bit clock, the word committed is the last 16 bits sampled before the latch line rises, whatever came before it.
- R2: A burst of exactly 16 bit-clock pulses followed by a latch rise commits that word.
- R3: Word bits [1:0] select the target register: 00 control 0, 01 control 1, 10 left volume, 11 right volume. A write changes only the register it selects.
- R4: Control 0 maps word bits as follows: 15 power down, 14 mute, [13:12] input type, [11:10] output format (00 stereo, 10 mono left, 11 mono right), [9:8] sample rate, [7:6] de-emphasis, [5:4] serial format, [3:2] word width.
- R5: Control 1 maps word bits as follows: [10:9] master clock ratio, 8 zero-flag polarity, 7 bit rate, 6 phase mode, [5:4] phase select, 3 bit inversion, 2 bit-clock edge select. Bits [15:11] are ignored.
- R6: Each volume register takes word bits [15:2] as a 14-bit unsigned value.
- R7: While rst_ni is low, every control field reads zero and both volumes read all ones. Reset acts at once, even in the middle of a word.
- R8: A control-0 write with output format 01 is discarded whole: every control-0 output keeps its previous value.
- R9: A committed word appears on the outputs at the third rising sample-clock edge after the latch rise, with all of its fields changing in the same cycle. The outputs do not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial bit clock |
| sdata_i | input | 1 | Serial data, MSB first |
| latch_i | input | 1 | Word commit, rising edge |
| clk_i | input | 1 | Audio sample-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_down_o | output | 1 | Power down |
| mute_o | output | 1 | Mute |
| in_type_o | output | 2 | Input data type |
| out_fmt_o | output | 2 | Output channel format |
| rate_o | output | 2 | Sample rate select |
| deemph_o | output | 2 | De-emphasis select |
| ser_fmt_o | output | 2 | Serial audio format |
| word_len_o | output | 2 | Audio word width |
| mclk_ratio_o | output | 2 | Master clock ratio |
| zflag_pol_o | output | 1 | Zero flag polarity |
| bit_rate_o | output | 1 | Bitstream rate |
| phase_mode_o | output | 1 | Phase mode enable |
| phase_sel_o | output | 2 | Phase select |
| bit_inv_o | output | 1 | Bitstream inversion |
| bclk_edge_o | output | 1 | Bit clock to master clock edge |
| vol_l_o | output | 14 | Left volume |
| vol_r_o | output | 14 | Right volume |

## Verification
The bench sends words with a free-running bit clock. Junk bits come before and after each word, so a design that framed by bit count instead of by the latch would commit a shifted word. It writes each address in turn and compares all four registers against a reference model on every sample-clock cycle. A wrong decode would corrupt a neighbouring register, and a crossing that was one cycle late or early, or that tore a word, would be flagged in the exact cycle it happened. It sends a control-0 word carrying the forbidden format code. A design that filtered only the format field would still change mute or power down. It also drops reset in the middle of a word, which catches leftover shift state or missed defaults.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  typedef enum logic [1:0] {
    REG_CTRL0 = 2'b00,
    REG_CTRL1 = 2'b01,
    REG_VOL_L = 2'b10,
    REG_VOL_R = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    FMT_STEREO = 2'b00,
    FMT_FORBID = 2'b01,
    FMT_MONO_L = 2'b10,
    FMT_MONO_R = 2'b11
  } out_fmt_e;

  // bit-exact image of control 0 word bits [15:2]
  typedef struct packed {
    logic       pwr_down;
    logic       mute;
    logic [1:0] in_type;
    logic [1:0] out_fmt;
    logic [1:0] rate;
    logic [1:0] deemph;
    logic [1:0] ser_fmt;
    logic [1:0] word_len;
  } ctrl0_t;

  // bit-exact image of control 1 word bits [10:2]
  typedef struct packed {
    logic [1:0] mclk_ratio;
    logic       zflag_pol;
    logic       bit_rate;
    logic       phase_mode;
    logic [1:0] phase_sel;
    logic       bit_inv;
    logic       bclk_edge;
  } ctrl1_t;

  localparam int unsigned CTRL0_W = $bits(ctrl0_t);
  localparam int unsigned CTRL1_W = $bits(ctrl1_t);

endpackage

// File: rtl/sctl_shift_capture.sv
module sctl_shift_capture #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              latch_i,
  input  logic              rst_ni,
  output logic [WORD_W-1:0] word_o,
  output logic              tgl_o
);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] hold_q;
  logic              tgl_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else         shreg_q <= {shreg_q[WORD_W-2:0], sdata_i};
  end

  // latch edge clocks the capture, so a stopped bit clock still commits
  always_ff @(posedge latch_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      hold_q <= shreg_q;
      tgl_q  <= ~tgl_q;
    end
  end

  assign word_o = hold_q;
  assign tgl_o  = tgl_q;

endmodule

// File: rtl/sctl_toggle_sync.sv
module sctl_toggle_sync #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgl_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= tgl_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= sync_q[LAST];
  end

  assign load_o = sync_q[LAST] ^ seen_q;
  // capture word is quiet for SYNC_STAGES cycles before load
  assign word_o = word_i;

endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned VOL_W  = WORD_W - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output ctrl0_t            ctrl0_o,
  output ctrl1_t            ctrl1_o,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [VOL_W-1:0]  vol_r_o
);

  reg_sel_e   sel;
  ctrl0_t     c0_new;
  ctrl1_t     c1_new;
  logic       c0_ok;
  ctrl0_t     c0_q;
  ctrl1_t     c1_q;
  logic [VOL_W-1:0] vl_q, vr_q;

  assign sel    = reg_sel_e'(word_i[ADDR_W-1:0]);
  assign c0_new = ctrl0_t'(word_i[ADDR_W +: CTRL0_W]);
  assign c1_new = ctrl1_t'(word_i[ADDR_W +: CTRL1_W]);
  assign c0_ok  = out_fmt_e'(c0_new.out_fmt) != FMT_FORBID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c0_q <= '0;
      c1_q <= '0;
      vl_q <= '1;
      vr_q <= '1;
    end else if (load_i) begin
      unique case (sel)
        REG_CTRL0: if (c0_ok) c0_q <= c0_new;
        REG_CTRL1: c1_q <= c1_new;
        REG_VOL_L: vl_q <= word_i[WORD_W-1:ADDR_W];
        REG_VOL_R: vr_q <= word_i[WORD_W-1:ADDR_W];
        default: ;
      endcase
    end
  end

  assign ctrl0_o = c0_q;
  assign ctrl1_o = c1_q;
  assign vol_l_o = vl_q;
  assign vol_r_o = vr_q;

endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import sctl_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned VOL_W      = WORD_W - ADDR_W
) (
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             latch_i,
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             pwr_down_o,
  output logic             mute_o,
  output logic [1:0]       in_type_o,
  output logic [1:0]       out_fmt_o,
  output logic [1:0]       rate_o,
  output logic [1:0]       deemph_o,
  output logic [1:0]       ser_fmt_o,
  output logic [1:0]       word_len_o,
  output logic [1:0]       mclk_ratio_o,
  output logic             zflag_pol_o,
  output logic             bit_rate_o,
  output logic             phase_mode_o,
  output logic [1:0]       phase_sel_o,
  output logic             bit_inv_o,
  output logic             bclk_edge_o,
  output logic [VOL_W-1:0] vol_l_o,
  output logic [VOL_W-1:0] vol_r_o
);

  logic [WORD_W-1:0] cap_word;
  logic              cap_tgl;
  logic              cdc_load;
  logic [WORD_W-1:0] cdc_word;
  ctrl0_t            ctrl0_q;
  ctrl1_t            ctrl1_q;

  sctl_shift_capture #(.WORD_W(WORD_W)) u_cap (
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .latch_i (latch_i),
    .rst_ni  (rst_ni),
    .word_o  (cap_word),
    .tgl_o   (cap_tgl)
  );

  sctl_toggle_sync #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (cap_tgl),
    .word_i (cap_word),
    .load_o (cdc_load),
    .word_o (cdc_word)
  );

  sctl_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .VOL_W(VOL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cdc_load),
    .word_i  (cdc_word),
    .ctrl0_o (ctrl0_q),
    .ctrl1_o (ctrl1_q),
    .vol_l_o (vol_l_o),
    .vol_r_o (vol_r_o)
  );

  assign pwr_down_o   = ctrl0_q.pwr_down;
  assign mute_o       = ctrl0_q.mute;
  assign in_type_o    = ctrl0_q.in_type;
  assign out_fmt_o    = ctrl0_q.out_fmt;
  assign rate_o       = ctrl0_q.rate;
  assign deemph_o     = ctrl0_q.deemph;
  assign ser_fmt_o    = ctrl0_q.ser_fmt;
  assign word_len_o   = ctrl0_q.word_len;
  assign mclk_ratio_o = ctrl1_q.mclk_ratio;
  assign zflag_pol_o  = ctrl1_q.zflag_pol;
  assign bit_rate_o   = ctrl1_q.bit_rate;
  assign phase_mode_o = ctrl1_q.phase_mode;
  assign phase_sel_o  = ctrl1_q.phase_sel;
  assign bit_inv_o    = ctrl1_q.bit_inv;
  assign bclk_edge_o  = ctrl1_q.bclk_edge;

endmodule

// File: rtl/sctl_checker.sv
module sctl_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned C0_W   = 14,
  parameter int unsigned C1_W   = 9,
  localparam int unsigned VOL_W = WORD_W - ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [WORD_W-1:0] word_i,
  input logic [1:0]        out_fmt_i,
  input logic [C0_W-1:0]   ctrl0_i,
  input logic [C1_W-1:0]   ctrl1_i,
  input logic [VOL_W-1:0]  vol_l_i,
  input logic [VOL_W-1:0]  vol_r_i
);

  assert_fmt_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fmt_i != 2'b01);

  assert_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && word_i[1:0] == 2'b00 && word_i[11:10] == 2'b01) |=> $stable(ctrl0_i));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({ctrl0_i, ctrl1_i, vol_l_i, vol_r_i}));

  assert_decode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && word_i[1:0] == 2'b10) |=> $stable({ctrl0_i, ctrl1_i, vol_r_i}));

  assert_vol_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && word_i[1:0] == 2'b11) |=> vol_r_i == $past(word_i[WORD_W-1:ADDR_W]));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_defaults_R7: assert (ctrl0_i == '0 && ctrl1_i == '0 &&
                                  vol_l_i == '1 && vol_r_i == '1);
    end
  end

endmodule

bind serial_ctrl_regs sctl_checker #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W),
  .C0_W(sctl_pkg::CTRL0_W), .C1_W(sctl_pkg::CTRL1_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (cdc_load),
  .word_i    (cdc_word),
  .out_fmt_i (out_fmt_o),
  .ctrl0_i   (ctrl0_q),
  .ctrl1_i   (ctrl1_q),
  .vol_l_i   (vol_l_o),
  .vol_r_i   (vol_r_o)
);

// File: tb/tb_serial_ctrl_regs.sv
`timescale 1ns/1ps
module tb_serial_ctrl_regs;

  logic clk = 1'b0;
  logic rst_ni;
  logic sclk = 1'b0, sdata = 1'b0, latch = 1'b0;

  logic pwr_down, mute, zflag_pol, bit_rate, phase_mode, bit_inv, bclk_edge;
  logic [1:0] in_type, out_fmt, rate, deemph, ser_fmt, word_len, mclk_ratio, phase_sel;
  logic [13:0] vol_l, vol_r;

  always #2.5 clk = ~clk;

  serial_ctrl_regs dut (
    .sclk_i(sclk), .sdata_i(sdata), .latch_i(latch), .clk_i(clk), .rst_ni(rst_ni),
    .pwr_down_o(pwr_down), .mute_o(mute), .in_type_o(in_type), .out_fmt_o(out_fmt),
    .rate_o(rate), .deemph_o(deemph), .ser_fmt_o(ser_fmt), .word_len_o(word_len),
    .mclk_ratio_o(mclk_ratio), .zflag_pol_o(zflag_pol), .bit_rate_o(bit_rate),
    .phase_mode_o(phase_mode), .phase_sel_o(phase_sel), .bit_inv_o(bit_inv),
    .bclk_edge_o(bclk_edge), .vol_l_o(vol_l), .vol_r_o(vol_r)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0, started = 1'b0;

  // reference model: register images as the bench reads them back
  logic [15:0] exp_c0 = 16'h0000, exp_c1 = 16'h0000;
  logic [13:0] exp_vl = 14'h3FFF, exp_vr = 14'h3FFF;
  logic [15:0] pend_word;
  int          pend_cnt = 0;

  function automatic logic [15:0] act_c0();
    return {pwr_down, mute, in_type, out_fmt, rate, deemph, ser_fmt, word_len, 2'b00};
  endfunction
  function automatic logic [15:0] act_c1();
    return {5'b0, mclk_ratio, zflag_pol, bit_rate, phase_mode, phase_sel, bit_inv, bclk_edge, 2'b00};
  endfunction

  task automatic model_apply(input logic [15:0] w);
    case (w[1:0])
      2'b00: if (w[11:10] != 2'b01) exp_c0 = w & 16'hFFFC;
      2'b01: exp_c1 = w & 16'h07FC;
      2'b10: exp_vl = w[15:2];
      default: exp_vr = w[15:2];
    endcase
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_c0 = 16'h0; exp_c1 = 16'h0; exp_vl = 14'h3FFF; exp_vr = 14'h3FFF;
      pend_cnt = 0;
    end else if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) model_apply(pend_word);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act %h exp %h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare: R9 timing together with field maps R4 R5 R6
  always @(negedge clk) begin
    if (started) begin
      chk("R9 R4 ctrl0", {16'h0, act_c0()}, {16'h0, exp_c0});
      chk("R9 R5 ctrl1", {16'h0, act_c1()}, {16'h0, exp_c1});
      chk("R9 R6 vol_l", {18'h0, vol_l}, {18'h0, exp_vl});
      chk("R9 R6 vol_r", {18'h0, vol_r}, {18'h0, exp_vr});
    end
  end

  task automatic shift_bit(input logic b);
    #3 sclk = 1'b0; sdata = b;
    #4 sclk = 1'b1;
  endtask

  task automatic send(input logic [15:0] w, input int pre, input int post);
    for (int i = 0; i < pre; i++) shift_bit(i[0] ^ i[2]);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    @(negedge clk);
    latch = 1'b1;
    pend_word = w;
    pend_cnt = 3;
    #6 latch = 1'b0;
    for (int i = 0; i < post; i++) shift_bit(~i[1]);
    #3 sclk = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    started = 1'b1;
    repeat (3) @(negedge clk);
    // R7 defaults
    chk("R7 vol_l default", {18'h0, vol_l}, 32'h3FFF);
    chk("R7 ctrl0 default", {16'h0, act_c0()}, 32'h0);
    #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 burst, R4 control 0 fields: pd=1 mute=0 in=10 fmt=11 rate=10 de=01 ser=11 wl=01
    send({1'b1, 1'b0, 2'b10, 2'b11, 2'b10, 2'b01, 2'b11, 2'b01, 2'b00}, 0, 0);
    chk("R2 R4 pwr_down", {31'h0, pwr_down}, 32'h1);
    chk("R4 in_type", {30'h0, in_type}, 32'h2);
    chk("R4 out_fmt", {30'h0, out_fmt}, 32'h3);
    chk("R4 word_len", {30'h0, word_len}, 32'h1);

    // R1 free-running clock with junk around, R5 control 1 fields
    send({5'b10101, 2'b11, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 2'b01}, 20, 9);
    chk("R1 R5 mclk_ratio", {30'h0, mclk_ratio}, 32'h3);
    chk("R5 phase_sel", {30'h0, phase_sel}, 32'h2);
    chk("R5 zflag_pol", {31'h0, zflag_pol}, 32'h1);

    // R3 R6 left volume, right untouched
    send({14'h1234, 2'b10}, 3, 4);
    chk("R6 vol_l", {18'h0, vol_l}, 32'h1234);
    chk("R3 vol_r untouched", {18'h0, vol_r}, 32'h3FFF);

    send({14'h0AB5, 2'b11}, 17, 0);
    chk("R6 vol_r", {18'h0, vol_r}, 32'h0AB5);
    chk("R3 vol_l untouched", {18'h0, vol_l}, 32'h1234);

    // R8 forbidden format: whole write discarded
    send({1'b0, 1'b1, 2'b01, 2'b01, 2'b00, 2'b10, 2'b00, 2'b11, 2'b00}, 5, 2);
    chk("R8 mute kept", {31'h0, mute}, 32'h0);
    chk("R8 pwr_down kept", {31'h0, pwr_down}, 32'h1);
    chk("R8 out_fmt kept", {30'h0, out_fmt}, 32'h3);

    // legal mono-left write after rejection
    send({1'b0, 1'b1, 2'b01, 2'b10, 2'b01, 2'b10, 2'b00, 2'b11, 2'b00}, 0, 0);
    chk("R4 mute set", {31'h0, mute}, 32'h1);
    chk("R4 out_fmt mono left", {30'h0, out_fmt}, 32'h2);

    // R7 reset mid-word
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    @(negedge clk); #1 rst_ni = 1'b0;
    @(negedge clk);
    chk("R7 vol_l reset", {18'h0, vol_l}, 32'h3FFF);
    chk("R7 mute reset", {31'h0, mute}, 32'h0);
    chk("R7 ctrl1 reset", {16'h0, act_c1()}, 32'h0);
    #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    send({14'h2001, 2'b10}, 0, 0);
    chk("R2 R7 vol_l after reset", {18'h0, vol_l}, 32'h2001);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule